// File: doc/BRIEF.md
# Synchronous Receiver with Sync Hunt

This block is the receive side of a synchronous serial link. One bit arrives on `rxBit` in each clock cycle where `bitEn` is high. After a hunt command the block searches the bit stream for the programmed sync pattern. The pattern is one character, or two characters that must arrive back to back. Instead of that internal search, the block can also lock onto a pulse on an external sync-detect input. Once locked, it frames characters of 5 to 8 bits into a holding register that a CPU reads.

The CPU reads a data register and a status register. Each read is gated by chip select. The status word holds a sync-detected flag, a data-ready flag and an overrun flag. Clear-on-read side effects take place when a read access ends. While a status read is in progress, the status word is frozen.

Top module: `syncrx_top`

## Requirements
- R1: Character length is `5 + lenSel` bits. Bits arrive least significant first. A completed character is right-aligned in the data register, and the unused upper bits read as zero.
- R2: In internal mode with `dblSync` low, sync is declared when the last N received bits (N = character length) equal the low N bits of `sync1`. The next bit is the first bit of the first character.
- R3: With `dblSync` high, sync is declared only when the N bits that immediately follow a `sync1` match equal `sync2`. If they do not match, the block returns to hunting.
- R4: An `enterHunt` pulse returns the block to hunting, clears the sync-detected flag and fills the shift register with ones. Bits received before the pulse therefore cannot complete a sync match.
- R5: With `extMode` high, the internal comparison is disabled. A rising edge on `extSyncIn` sets the sync-detected flag. If the block is hunting, that edge also starts framing at the next bit.
- R6: The sync-detected and overrun flags clear when a status read ends, but only if they were set when the read began. A flag that is set during the read survives.
- R7: `regSel` = 1 selects status: bit0 is data-ready, bit1 is overrun, bit2 is sync-detected and the other bits are zero. While a status read is active (`chipSel`, `readStb` and `regSel` all high), the status value does not change.
- R8: Each completed character loads the data register (`regSel` = 0) and sets data-ready. A data read clears data-ready when the read ends.
- R9: If a character completes while data-ready is still set, overrun is set and the new character replaces the old one.
- R10: While `chipSel` is low, `readStb` has no effect on any flag.
- R11: After reset the block is hunting, the shift register holds all ones, and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Receive bit strobe |
| rxBit | input | 1 | Serial receive data |
| enterHunt | input | 1 | Hunt command pulse |
| lenSel | input | 2 | Character length code (length = 5 + code) |
| dblSync | input | 1 | Two sync characters required |
| extMode | input | 1 | External sync-detect selected |
| sync1 | input | 8 | First sync character |
| sync2 | input | 8 | Second sync character |
| extSyncIn | input | 1 | External sync-detect input |
| chipSel | input | 1 | Chip select for reads |
| readStb | input | 1 | Read strobe |
| regSel | input | 1 | 0 = data register, 1 = status register |
| rdData | output | 8 | Read data |

## Verification
The bench targets these corner cases:
- **Stale bits after a hunt command.** It stops a sync pattern midway, issues a hunt, then sends the remaining bits. A design without the all-ones fill would report a false lock.
- **Gap in the double-sync pair.** It inserts a one-bit gap between the two sync characters. A design that does not insist on back-to-back arrival would declare sync.
- **Event during a long status read.** An external event arrives while a status read is held open. A design that does not freeze the status word would change it mid-read. A design that clears every flag at the end of the read would lose the event.
- **Overrun and the chip-select gate.** It sends two unread characters, then toggles the read strobe with chip select low. It also runs constrained-random hunts that cover all lengths and both sync modes.

// File: rtl/syncrx_pkg.sv
package syncrx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_DATA  = 2'd2
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic presetSr;
    logic shiftEn;
    logic cntClr;
    logic loadHold;
  } dpCtrl_t;

  // status word, bit2 = sync, bit1 = overrun, bit0 = ready
  typedef struct packed {
    logic syn;
    logic ovr;
    logic rdy;
  } rxStat_t;

endpackage

// File: rtl/syncrx_datapath.sv
module syncrx_datapath
  import syncrx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int MIN_LEN = 5,
  parameter int LSEL_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctl,
  input  logic                       rxBit,
  input  logic [LSEL_W-1:0]          lenSel,
  input  logic [MAX_LEN-1:0]         sync1,
  input  logic [MAX_LEN-1:0]         sync2,
  output logic                       match1,
  output logic                       match2,
  output logic                       lastBit,
  output logic [MAX_LEN-1:0]         holdQ,
  output logic [MAX_LEN-1:0]         srQ,
  output logic [$clog2(MAX_LEN)-1:0] bitCnt
);

  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0]   charLen;
  logic [LEN_W-1:0]   shAmt;
  logic [MAX_LEN-1:0] srNext;
  logic [MAX_LEN-1:0] window;
  logic [MAX_LEN-1:0] lenMask;

  assign charLen = LEN_W'(MIN_LEN) + LEN_W'(lenSel);
  assign shAmt   = LEN_W'(MAX_LEN) - charLen;

  // newest bit enters at the top, oldest (LSB) falls off the bottom
  assign srNext = {rxBit, srQ[MAX_LEN-1:1]};
  assign window = srNext >> shAmt;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_mask
    assign lenMask[i] = (LEN_W'(i) < charLen);
  end

  assign match1  = (window == (sync1 & lenMask));
  assign match2  = (window == (sync2 & lenMask));
  assign lastBit = (LEN_W'(bitCnt) == (charLen - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ <= '1;
    end else if (ctl.presetSr) begin
      srQ <= '1;
    end else if (ctl.shiftEn) begin
      srQ <= srNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.shiftEn) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (ctl.loadHold) begin
      holdQ <= window;
    end
  end

endmodule

// File: rtl/syncrx_ctrl.sv
module syncrx_ctrl
  import syncrx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitEn,
  input  logic     enterHunt,
  input  logic     extMode,
  input  logic     dblSync,
  input  logic     extSyncIn,
  input  logic     match1,
  input  logic     match2,
  input  logic     lastBit,
  input  logic     chipSel,
  input  logic     readStb,
  input  logic     regSel,
  output dpCtrl_t  ctl,
  output rxState_t state,
  output rxStat_t  liveQ,
  output rxStat_t  statusQ
);

  logic     stRd, dRd, stRdQ, dRdQ, stEnd, dEnd;
  logic     extPrevQ, extRise;
  logic     evSyn, evChar;
  rxState_t nextState;
  rxStat_t  liveNext;

  // read decode; side effects fire when the access ends
  assign stRd    = chipSel & readStb & regSel;
  assign dRd     = chipSel & readStb & ~regSel;
  assign stEnd   = stRdQ & ~stRd;
  assign dEnd    = dRdQ & ~dRd;
  assign extRise = extMode & extSyncIn & ~extPrevQ;

  always_comb begin
    ctl       = '0;
    nextState = state;
    evSyn     = 1'b0;
    evChar    = 1'b0;
    if (enterHunt) begin
      ctl.presetSr = 1'b1;
      ctl.cntClr   = 1'b1;
      nextState    = ST_HUNT;
    end else begin
      if (extRise) begin
        evSyn = 1'b1;
        if (state == ST_HUNT) begin
          nextState  = ST_DATA;
          ctl.cntClr = 1'b1;
        end
      end
      if (bitEn) begin
        ctl.shiftEn = 1'b1;
        unique case (state)
          ST_HUNT: begin
            ctl.cntClr = 1'b1;
            if (!extMode && match1) begin
              if (dblSync) begin
                nextState = ST_SYNC2;
              end else begin
                nextState = ST_DATA;
                evSyn     = 1'b1;
              end
            end
          end
          ST_SYNC2: begin
            if (lastBit) begin
              ctl.cntClr = 1'b1;
              if (match2) begin
                nextState = ST_DATA;
                evSyn     = 1'b1;
              end else begin
                nextState = ST_HUNT;
              end
            end
          end
          ST_DATA: begin
            if (lastBit) begin
              ctl.loadHold = 1'b1;
              ctl.cntClr   = 1'b1;
              evChar       = 1'b1;
            end
          end
          default: nextState = ST_HUNT;
        endcase
      end
    end
  end

  // live flags always track events; statusQ is the frozen copy the CPU sees
  always_comb begin
    liveNext.syn = enterHunt ? 1'b0
                 : ((liveQ.syn & ~(stEnd & statusQ.syn)) | evSyn);
    liveNext.rdy = (liveQ.rdy & ~dEnd) | evChar;
    liveNext.ovr = (liveQ.ovr & ~(stEnd & statusQ.ovr))
                 | (evChar & liveQ.rdy & ~dEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      liveQ    <= '0;
      statusQ  <= '0;
      stRdQ    <= 1'b0;
      dRdQ     <= 1'b0;
      extPrevQ <= 1'b0;
    end else begin
      state    <= nextState;
      liveQ    <= liveNext;
      if (!stRd) begin
        statusQ <= liveNext;
      end
      stRdQ    <= stRd;
      dRdQ     <= dRd;
      extPrevQ <= extSyncIn;
    end
  end

endmodule

// File: rtl/syncrx_top.sv
module syncrx_top
  import syncrx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int MIN_LEN = 5,
  parameter int LSEL_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitEn,
  input  logic               rxBit,
  input  logic               enterHunt,
  input  logic [LSEL_W-1:0]  lenSel,
  input  logic               dblSync,
  input  logic               extMode,
  input  logic [MAX_LEN-1:0] sync1,
  input  logic [MAX_LEN-1:0] sync2,
  input  logic               extSyncIn,
  input  logic               chipSel,
  input  logic               readStb,
  input  logic               regSel,
  output logic [MAX_LEN-1:0] rdData
);

  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int STAT_W = $bits(rxStat_t);

  dpCtrl_t            dpCtl;
  rxState_t           state;
  rxStat_t            liveQ, statusQ;
  logic               match1, match2, lastBit;
  logic [MAX_LEN-1:0] holdQ, srQ;
  logic [CNT_W-1:0]   bitCnt;

  syncrx_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .enterHunt (enterHunt),
    .extMode   (extMode),
    .dblSync   (dblSync),
    .extSyncIn (extSyncIn),
    .match1    (match1),
    .match2    (match2),
    .lastBit   (lastBit),
    .chipSel   (chipSel),
    .readStb   (readStb),
    .regSel    (regSel),
    .ctl       (dpCtl),
    .state     (state),
    .liveQ     (liveQ),
    .statusQ   (statusQ)
  );

  syncrx_datapath #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN),
    .LSEL_W  (LSEL_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .rxBit   (rxBit),
    .lenSel  (lenSel),
    .sync1   (sync1),
    .sync2   (sync2),
    .match1  (match1),
    .match2  (match2),
    .lastBit (lastBit),
    .holdQ   (holdQ),
    .srQ     (srQ),
    .bitCnt  (bitCnt)
  );

  assign rdData = regSel ? {{(MAX_LEN-STAT_W){1'b0}}, statusQ} : holdQ;

endmodule

// File: rtl/syncrx_checker.sv
module syncrx_checker
  import syncrx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int MIN_LEN = 5,
  parameter int LSEL_W  = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       bitEn,
  input logic                       enterHunt,
  input logic                       extMode,
  input logic                       extSyncIn,
  input logic                       chipSel,
  input logic                       readStb,
  input logic                       regSel,
  input logic [LSEL_W-1:0]          lenSel,
  input logic [MAX_LEN-1:0]         rdData,
  input logic [MAX_LEN-1:0]         srQ,
  input logic [$clog2(MAX_LEN)-1:0] bitCnt,
  input rxState_t                   state,
  input logic                       loadHold,
  input logic                       liveRdy,
  input rxStat_t                    statusQ
);

  logic stRdNow;
  assign stRdNow = chipSel && readStb && regSel;

  // R1: a character is taken only on its final bit
  a_r1_boundary: assert property (@(posedge clk) disable iff (!rstN)
    loadHold |-> (int'(bitCnt) == MIN_LEN + int'(lenSel) - 1));

  // R4: hunt command fills the shift register with ones
  a_r4_hunt_preset: assert property (@(posedge clk) disable iff (!rstN)
    enterHunt |=> (srQ == '1) && (state == ST_HUNT));

  // R5: in external mode only the sync input can end the hunt
  a_r5_ext_blocks_internal: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && state == ST_HUNT && !extSyncIn && !enterHunt) |=> state == ST_HUNT);

  // R7: status word does not move during a status read
  a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    stRdNow |=> (stRdNow -> $stable(rdData)));

  // R8: data-ready only rises after a character load
  a_r8_rdy_from_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(liveRdy) |-> $past(loadHold));

  // R10: with chip select low and no receive activity, status holds
  a_r10_cs_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSel && !$past(chipSel) && !bitEn && !enterHunt && !extMode) |=> $stable(statusQ));

endmodule

bind syncrx_top syncrx_checker #(
  .MAX_LEN (MAX_LEN),
  .MIN_LEN (MIN_LEN),
  .LSEL_W  (LSEL_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .enterHunt (enterHunt),
  .extMode   (extMode),
  .extSyncIn (extSyncIn),
  .chipSel   (chipSel),
  .readStb   (readStb),
  .regSel    (regSel),
  .lenSel    (lenSel),
  .rdData    (rdData),
  .srQ       (srQ),
  .bitCnt    (bitCnt),
  .state     (state),
  .loadHold  (dpCtl.loadHold),
  .liveRdy   (liveQ.rdy),
  .statusQ   (statusQ)
);

// File: tb/test_syncrx_top.sv
module test_syncrx_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0, rxBit = 1'b0, enterHunt = 1'b0;
  logic [1:0] lenSel = 2'd3;
  logic       dblSync = 1'b0, extMode = 1'b0, extSyncIn = 1'b0;
  logic [7:0] sync1 = 8'h16, sync2 = 8'h16;
  logic       chipSel = 1'b0, readStb = 1'b0, regSel = 1'b0;
  logic [7:0] rdData;

  int nTests = 0, nFail = 0;
  bit done = 0;

  // reference state
  int         mState = 0, mCnt = 0;
  logic [7:0] mSr = 8'hFF, mHold = 8'h00;
  logic       mSyn = 0, mOvr = 0, mRdy = 0;

  always #5 clk = ~clk;

  syncrx_top i_syncrx_top (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .enterHunt(enterHunt),
    .lenSel(lenSel), .dblSync(dblSync), .extMode(extMode), .sync1(sync1), .sync2(sync2),
    .extSyncIn(extSyncIn), .chipSel(chipSel), .readStb(readStb), .regSel(regSel),
    .rdData(rdData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat();
    return {5'b0, mSyn, mOvr, mRdy};
  endfunction

  task automatic peek(input logic sel, output logic [7:0] v);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic modelBit(input logic b);
    int L = 5 + int'(lenSel);
    logic [7:0] w, m;
    mSr = {b, mSr[7:1]};
    w = mSr >> (8 - L);
    m = 8'hFF >> (8 - L);
    case (mState)
      0: begin
        mCnt = 0;
        if (!extMode && w == (sync1 & m)) begin
          if (dblSync) mState = 1;
          else begin mState = 2; mSyn = 1; end
        end
      end
      1: if (mCnt == L - 1) begin
           mCnt = 0;
           if (w == (sync2 & m)) begin mState = 2; mSyn = 1; end
           else mState = 0;
         end else mCnt++;
      default: if (mCnt == L - 1) begin
           mCnt = 0;
           if (mRdy) mOvr = 1;
           mHold = w; mRdy = 1;
         end else mCnt++;
    endcase
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitEn = 1'b1; rxBit = b;
    @(negedge clk); bitEn = 1'b0;
    modelBit(b);
  endtask

  task automatic sendChar(input logic [7:0] v);
    for (int i = 0; i < 5 + int'(lenSel); i++) sendBit(v[i]);
  endtask

  task automatic pulseHunt();
    @(negedge clk); enterHunt = 1'b1;
    @(negedge clk); enterHunt = 1'b0;
    mSr = 8'hFF; mState = 0; mCnt = 0; mSyn = 0;
  endtask

  task automatic extPulse();
    @(negedge clk); extSyncIn = 1'b1;
    @(negedge clk); extSyncIn = 1'b0;
    if (extMode) begin
      mSyn = 1;
      if (mState == 0) begin mState = 2; mCnt = 0; end
    end
  endtask

  task automatic readReg(input logic sel, output logic [7:0] v);
    @(negedge clk); chipSel = 1'b1; readStb = 1'b1; regSel = sel;
    #1 v = rdData;
    @(negedge clk); chipSel = 1'b0; readStb = 1'b0;
    @(negedge clk);
    if (sel) begin mSyn = 0; mOvr = 0; end
    else mRdy = 0;
  endtask

  task automatic compareAll(input string req);
    logic [7:0] v;
    peek(1'b1, v); chk(req, v, expStat());
    peek(1'b0, v); chk(req, v, mHold);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v0, v1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    peek(1'b1, v); chk("R11 status", v, 8'h00);
    peek(1'b0, v); chk("R11 data", v, 8'h00);

    // R2 single sync, R8 load, R1 length 8
    lenSel = 2'd3; sync1 = 8'h16; dblSync = 0; extMode = 0;
    pulseHunt();
    sendBit(1'b0); sendBit(1'b1);
    sendChar(8'h16);
    peek(1'b1, v); chk("R2 sync declared", v, 8'h04);
    readReg(1'b1, v); chk("R7 status value", v, 8'h04);
    sendChar(8'hA5);
    peek(1'b1, v); chk("R8 ready set", v, 8'h01);
    peek(1'b0, v); chk("R1 R8 data", v, 8'hA5);
    sendChar(8'h3C);
    peek(1'b1, v); chk("R9 overrun", v, 8'h03);
    peek(1'b0, v); chk("R9 overwrite", v, 8'h3C);

    // R10 strobes without chip select
    @(negedge clk); readStb = 1'b1; regSel = 1'b0;
    @(negedge clk); regSel = 1'b1;
    @(negedge clk); readStb = 1'b0;
    @(negedge clk);
    peek(1'b1, v); chk("R10 gated", v, 8'h03);

    readReg(1'b1, v); chk("R9 status read", v, 8'h03);
    peek(1'b1, v); chk("R9 overrun cleared", v, 8'h01);
    readReg(1'b0, v); chk("R8 data read", v, 8'h3C);
    peek(1'b1, v); chk("R8 ready cleared", v, 8'h00);

    // R4 stale bits cannot complete a sync after hunt
    pulseHunt();
    sendChar(8'h16);
    readReg(1'b1, v);
    sendBit(0); sendBit(1); sendBit(1); sendBit(0); sendBit(1);
    pulseHunt();
    sendBit(0); sendBit(0); sendBit(0);
    peek(1'b1, v); chk("R4 no false sync", v, 8'h00);
    compareAll("R4 model");

    // R1 length 5
    lenSel = 2'd0; sync1 = 8'h0B;
    pulseHunt();
    sendChar(8'h0B); sendChar(8'h13);
    peek(1'b0, v); chk("R1 five-bit char", v, 8'h13);
    peek(1'b1, v); chk("R2 five-bit sync", v, 8'h05);
    readReg(1'b0, v); readReg(1'b1, v);

    // R3 double sync, gap and mismatch
    lenSel = 2'd3; dblSync = 1; sync1 = 8'h16; sync2 = 8'h32;
    pulseHunt();
    sendChar(8'h16); sendBit(1'b0); sendChar(8'h32);
    peek(1'b1, v); chk("R3 gap rejected", v, 8'h00);
    sendChar(8'h16); sendChar(8'h33);
    peek(1'b1, v); chk("R3 mismatch rejected", v, 8'h00);
    sendChar(8'h16); sendChar(8'h32);
    peek(1'b1, v); chk("R3 pair accepted", v, 8'h04);
    sendChar(8'h5E);
    compareAll("R3 first char");
    readReg(1'b0, v); readReg(1'b1, v);

    // R5 external mode
    dblSync = 0; extMode = 1;
    pulseHunt();
    sendChar(8'h16);
    peek(1'b1, v); chk("R5 internal off", v, 8'h00);
    extPulse();
    peek(1'b1, v); chk("R5 ext sets flag", v, 8'h04);
    sendChar(8'h5A);
    peek(1'b0, v); chk("R5 framing after ext", v, 8'h5A);
    readReg(1'b1, v); chk("R6 read value", v, 8'h05);
    peek(1'b1, v); chk("R6 sync cleared", v, 8'h01);

    // R6 R7 event during a held status read
    @(negedge clk); chipSel = 1'b1; readStb = 1'b1; regSel = 1'b1;
    #1 v0 = rdData;
    @(negedge clk); extSyncIn = 1'b1;
    @(negedge clk); extSyncIn = 1'b0;
    #1 v1 = rdData;
    chk("R7 frozen", v1, v0);
    @(negedge clk); chipSel = 1'b0; readStb = 1'b0;
    @(negedge clk);
    mSyn = 1;
    peek(1'b1, v); chk("R6 event survives", v, 8'h05);
    readReg(1'b1, v);
    peek(1'b1, v); chk("R6 cleared later", v, 8'h01);
    readReg(1'b0, v);
    extMode = 0;

    // constrained random hunts
    for (int it = 0; it < 40; it++) begin
      lenSel = 2'($urandom % 4);
      dblSync = 1'($urandom % 2);
      sync1 = 8'($urandom); sync2 = 8'($urandom);
      pulseHunt();
      for (int k = 0; k < int'($urandom % 12); k++) sendBit(1'($urandom));
      sendChar(sync1);
      if (dblSync) sendChar(sync2);
      compareAll(dblSync ? "R3 random sync" : "R2 random sync");
      for (int c = 0; c < 1 + int'($urandom % 4); c++) begin
        sendChar(8'($urandom));
        compareAll("R1 R8 R9 random char");
        if ($urandom % 3 == 0) begin
          v0 = mHold; readReg(1'b0, v); chk("R8 random data read", v, v0);
        end
        if ($urandom % 4 == 0) begin
          v0 = expStat(); readReg(1'b1, v); chk("R6 random status read", v, v0);
        end
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule